// File: doc/BRIEF.md
# Serial Dual-Word Frequency Register

This block stores two frequency tuning words in a single shift register of twice the word width, filled one bit at a time from a serial data pin on its own serial clock. An active-low enable gates shifting, and a direction input picks whether the serial stream arrives most significant bit first or least significant bit first. A word-select input chooses which half of the register is presented as the active tuning word. A downstream accumulator input register loads that word.

The direction decides where a freshly loaded word lands. In most-significant-first mode, bits enter at bit 0 and travel upward, so one word ends in the lower half. In least-significant-first mode, bits enter at the top and travel downward, so one word ends in the upper half. When only one word is in use, the word select must therefore match the direction input. Two words are loaded by shifting twice the word width of bits. The output is combinational. A stage in another clock domain must sample it only after the serial clock has been quiet for at least one of its own setup intervals.

Top module: `freq_word_store`

## Requirements
- R1: The register holds 2*WORD_W bits. It changes only on a rising serial clock edge with `shift_en_n` low. With `shift_en_n` high, every bit is held regardless of `sdata`.
- R2: With `msb_first` = 1, a shift places `sdata` in bit 0 and moves every other bit up by one position. The old top bit is discarded.
- R3: With `msb_first` = 0, a shift places `sdata` in the top bit (2*WORD_W-1) and moves every other bit down by one position. The old bit 0 is discarded.
- R4: `tune_word` is bits WORD_W-1..0 when `sel_low` = 1 and bits 2*WORD_W-1..WORD_W when `sel_low` = 0. It follows `sel_low` without any serial clock edge, and selecting never alters the stored bits.
- R5: Driving `rst_n` low asynchronously clears all stored bits to zero, so both selections read zero.
- R6: A single word shifted WORD_W times most-significant-first reads back unchanged with `sel_low` = 1. A single word shifted least-significant-first reads back unchanged with `sel_low` = 0.
- R7: Shifting 2*WORD_W bits most-significant-first leaves the first word sent in the upper half (`sel_low` = 0) and the second word sent in the lower half (`sel_low` = 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial shift clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low clear |
| sdata | input | 1 | Serial data bit |
| shift_en_n | input | 1 | Active-low shift enable |
| msb_first | input | 1 | 1: most significant bit first, 0: least significant bit first |
| sel_low | input | 1 | 1: present lower half, 0: present upper half |
| tune_word | output | WORD_W | Selected tuning word |

## Verification
The bench builds the block with the default WORD_W of 32, which gives a 64-bit register. At this width, full single-word and double-word loads take only 32 and 64 serial cycles. The exact constants from the requirements can therefore be checked together with the bit-by-bit model comparison. The bench mixes the direction in the middle of a stream, loads words with the select mismatched to the direction, idles with `sdata` toggling, and clears the register while it is full. All of these stay within a few hundred cycles.

// File: rtl/freq_word_store.sv
module freq_word_store #(
  parameter int WORD_W = 32
) (
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              sdata,
  input  logic              shift_en_n,
  input  logic              msb_first,
  input  logic              sel_low,
  output logic [WORD_W-1:0] tune_word
);
  localparam int REG_W = 2 * WORD_W;

  logic [REG_W-1:0] sr;

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n)
      sr <= '0;
    else if (!shift_en_n)
      sr <= msb_first ? {sr[REG_W-2:0], sdata} : {sdata, sr[REG_W-1:1]};
  end

  assign tune_word = sel_low ? sr[WORD_W-1:0] : sr[REG_W-1:WORD_W];

  AST_IDLE_HOLD: assert property (@(posedge sclk) disable iff (!rst_n)
    shift_en_n |=> $stable(sr)); // R1
  AST_MSB_ENTRY: assert property (@(posedge sclk) disable iff (!rst_n)
    (!shift_en_n && msb_first) |=> (sr[0] == $past(sdata))); // R2
  AST_MSB_CLIMB: assert property (@(posedge sclk) disable iff (!rst_n)
    (!shift_en_n && msb_first) |=> (sr[REG_W-1:1] == $past(sr[REG_W-2:0]))); // R2
  AST_LSB_ENTRY: assert property (@(posedge sclk) disable iff (!rst_n)
    (!shift_en_n && !msb_first) |=> (sr[REG_W-1] == $past(sdata))); // R3
  AST_LSB_DESCEND: assert property (@(posedge sclk) disable iff (!rst_n)
    (!shift_en_n && !msb_first) |=> (sr[REG_W-2:0] == $past(sr[REG_W-1:1]))); // R3
  AST_LOW_PORT_ENTRY: assert property (@(posedge sclk) disable iff (!rst_n)
    (!shift_en_n && msb_first && sel_low) ##1 sel_low |-> (tune_word[0] == $past(sdata))); // R4
endmodule

// File: tb/freq_word_store_tb.sv
module freq_word_store_tb;
  localparam int W = 32;
  localparam int RW = 2 * W;

  logic sclk = 1'b0;
  logic rst_n = 1'b0;
  logic sdata = 1'b0;
  logic shift_en_n = 1'b1;
  logic msb_first = 1'b1;
  logic sel_low = 1'b1;
  logic [W-1:0] tune_word;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;
  string cur_req = "R1";
  int model[RW];

  freq_word_store #(.WORD_W(W)) u_dut (
    .sclk(sclk), .rst_n(rst_n), .sdata(sdata), .shift_en_n(shift_en_n),
    .msb_first(msb_first), .sel_low(sel_low), .tune_word(tune_word));

  always #10 sclk = ~sclk;

  always @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RW; i++) model[i] = 0;
    end else if (!shift_en_n) begin
      if (msb_first) begin
        for (int i = RW - 1; i > 0; i--) model[i] = model[i-1];
        model[0] = int'(sdata);
      end else begin
        for (int i = 0; i < RW - 1; i++) model[i] = model[i+1];
        model[RW-1] = int'(sdata);
      end
    end
  end

  function automatic logic [W-1:0] model_word(input logic lo);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = model[lo ? i : i + W][0];
    return r;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge sclk) begin
    if (rst_n && !done) check(cur_req, tune_word, model_word(sel_low));
  end

  task automatic step(input logic en_n, input logic dir, input logic b);
    @(negedge sclk); #2;
    shift_en_n = en_n; msb_first = dir; sdata = b;
  endtask

  task automatic load_msb(input logic [W-1:0] w);
    for (int i = W - 1; i >= 0; i--) step(1'b0, 1'b1, w[i]);
    step(1'b1, 1'b1, 1'b0);
  endtask

  task automatic load_lsb(input logic [W-1:0] w);
    for (int i = 0; i < W; i++) step(1'b0, 1'b0, w[i]);
    step(1'b1, 1'b0, 1'b0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge sclk);
      cycles++;
      if (cycles > 100000) begin
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
        finish_run();
      end
    end
  end

  initial begin
    #5;
    sel_low = 1'b1; #1; check("R5", tune_word, '0);
    sel_low = 1'b0; #1; check("R5", tune_word, '0);
    #30 rst_n = 1'b1;

    cur_req = "R6";
    sel_low = 1'b1;
    load_msb(32'hA5C3_1E77);
    @(negedge sclk); #3; check("R6", tune_word, 32'hA5C3_1E77);

    cur_req = "R1";
    for (int i = 0; i < 10; i++) step(1'b1, i[0], ~i[0]);
    @(negedge sclk); #3; check("R1", tune_word, 32'hA5C3_1E77);

    cur_req = "R4";
    sel_low = 1'b0; #1; check("R4", tune_word, 32'h0);
    sel_low = 1'b1; #1; check("R4", tune_word, 32'hA5C3_1E77);

    cur_req = "R7";
    load_msb(32'h1234_5678);
    load_msb(32'h9ABC_DEF0);
    @(negedge sclk); #3;
    sel_low = 1'b0; #1; check("R7", tune_word, 32'h1234_5678);
    sel_low = 1'b1; #1; check("R7", tune_word, 32'h9ABC_DEF0);

    cur_req = "R6";
    sel_low = 1'b0;
    load_lsb(32'h0F1E_2D3C);
    @(negedge sclk); #3; check("R6", tune_word, 32'h0F1E_2D3C);
    sel_low = 1'b1; #1; check("R3", tune_word, 32'h1234_5678);

    cur_req = "R2";
    sel_low = 1'b1;
    load_lsb(32'hCAFE_0001);
    @(negedge sclk); #3; check("R3", tune_word, 32'h0F1E_2D3C);

    cur_req = "R3";
    for (int i = 0; i < 40; i++) step(1'b0, (i % 3) == 0, ((i * 7) % 5) > 1);
    step(1'b1, 1'b0, 1'b0);
    cur_req = "R2";
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1, i[1]);
    step(1'b1, 1'b1, 1'b0);
    sel_low = 1'b0;
    @(negedge sclk); #3;

    cur_req = "R5";
    #3 rst_n = 1'b0; #1;
    sel_low = 1'b0; #1; check("R5", tune_word, '0);
    sel_low = 1'b1; #1; check("R5", tune_word, '0);
    @(negedge sclk); #2 rst_n = 1'b1;
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b1);
    @(negedge sclk); #3; check("R5", tune_word, '0);

    finish_run();
  end
endmodule